// File: doc/BRIEF.md
# Queue Doorbell Address Decoder

This block sits on the device side of a virtual-queue transport. It watches writes that land inside the notification window and turns each legal doorbell write into a one-cycle notify pulse. The pulse carries the 16-bit queue index that the driver wrote. Each queue owns a notify offset, given as an input. Its doorbell address is that offset scaled by an elaboration-time multiplier, plus a fixed window base.

A multiplier of zero folds every queue onto the base address. Several queues may also share one offset. In both cases the written value, not the address, says which queue is being notified. A write is ignored in any of these cases: it is not two bytes wide, it hits no doorbell address, it names a queue that does not exist, or it names a queue that is disabled. Each ignored write is flagged for one cycle and counted in a saturating counter.

A side port returns the doorbell address of any selected queue, so software or a bench can check the layout. The multiplier is validated when the design is elaborated.

Top module: `ntf_decoder`

## Requirements
- R1: The query port returns, for queue `qry_sel`, the address `BASE_OFF + notify_offset[qry_sel] * MULT`, combinationally.
- R2: With `MULT` = 0, every queue's doorbell address equals `BASE_OFF`, and a legal write to `BASE_OFF` notifies whatever queue index it carries.
- R3: A legal write raises `ntf_valid` for exactly the cycle after the write edge, with `ntf_qidx` equal to the written 16-bit value. `ntf_valid` is low in every cycle that does not follow a legal write.
- R4: A write whose data is not below `NUM_Q` produces no notify.
- R5: A write naming a queue whose `q_enable` bit is low produces no notify.
- R6: Only writes with `wr_size` = 1 (two bytes) are decoded. The size codes are 0 = one byte, 1 = two bytes, 2 = four bytes, 3 = eight bytes. Any other size produces no notify.
- R7: A write to an address that equals no queue's doorbell address produces no notify.
- R8: When queues share a notify offset, a legal write to the shared address notifies the queue named by the data.
- R9: Every ignored write raises `drop_valid` for the cycle after its edge and increments `drop_cnt`, which saturates at its all-ones value. Legal writes never touch either output. `ntf_valid` and `drop_valid` are never high together.
- R10: While `rst_n` is low, `ntf_valid`, `ntf_qidx`, `drop_valid` and `drop_cnt` are all zero.
- R11: `MULT` must be 0, or an even power of two that is at least 2. The value 1 is reserved. `BASE_OFF` must be even. Any other setting fails an elaboration-time check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A write into the notification window is present |
| wr_addr | input | ADDR_W | Byte address of the write within the mapped region |
| wr_size | input | 2 | Write width code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes |
| wr_data | input | 16 | Written value (queue index) |
| q_notify_off | input | NUM_Q*OFF_W | Per-queue notify offsets; queue q occupies bits [q*OFF_W +: OFF_W] |
| q_enable | input | NUM_Q | Per-queue enable |
| qry_sel | input | QSEL_W | Queue selected for address query |
| qry_addr | output | ADDR_W | Doorbell address of the selected queue |
| ntf_valid | output | 1 | One-cycle notify pulse |
| ntf_qidx | output | 16 | Queue index carried by the notify |
| drop_valid | output | 1 | One-cycle pulse for an ignored write |
| drop_cnt | output | DROP_W | Saturating count of ignored writes |

## Verification
The assertions assume that `wr_addr`, `wr_size` and `wr_data` hold defined values whenever `wr_valid` is high. They also assume that `q_enable` and `q_notify_off` are stable during a write cycle, since the enable check compares against the enable sampled with the write. The stimulus changes every input only on the falling clock edge. It alters the enables and offsets only while `wr_valid` is low, and it keeps all inputs at zero during reset. The sweeps run over an address span that brackets every doorbell address, over all four size codes, and over indices beyond the queue count. Two instances receive the same stimulus, one with a scaling multiplier and one with a zero multiplier.

// File: rtl/ntf_pkg.sv
package ntf_pkg;

  typedef enum logic [1:0] {
    WSZ_8  = 2'd0,
    WSZ_16 = 2'd1,
    WSZ_32 = 2'd2,
    WSZ_64 = 2'd3
  } wr_size_e;

  // Legal scaling: zero, or a power of two of at least 2 (hence even).
  function automatic bit mult_is_legal(input int unsigned m);
    if (m == 0) return 1'b1;
    if (m < 2) return 1'b0;
    return ((m & (m - 1)) == 0);
  endfunction

endpackage

// File: rtl/ntf_addr_calc.sv
module ntf_addr_calc #(
  parameter int unsigned NUM_Q    = 4,
  parameter int unsigned OFF_W    = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned MULT     = 4,
  parameter int unsigned BASE_OFF = 256
) (
  input  logic [NUM_Q*OFF_W-1:0]  q_off_flat,
  output logic [NUM_Q*ADDR_W-1:0] q_addr_flat
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_OFF);

  generate
    if (MULT == 0) begin : g_shared
      for (genvar q = 0; q < int'(NUM_Q); q++) begin : g_q
        assign q_addr_flat[q*ADDR_W +: ADDR_W] = BASE_A;
      end
    end else begin : g_scaled
      localparam int unsigned SH = $clog2(MULT);
      for (genvar q = 0; q < int'(NUM_Q); q++) begin : g_q
        logic [ADDR_W-1:0] off_ext;
        assign off_ext = ADDR_W'(q_off_flat[q*OFF_W +: OFF_W]);
        assign q_addr_flat[q*ADDR_W +: ADDR_W] = BASE_A + (off_ext << SH);
      end
    end
  endgenerate

endmodule

// File: rtl/ntf_addr_match.sv
module ntf_addr_match #(
  parameter int unsigned NUM_Q  = 4,
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [NUM_Q*ADDR_W-1:0] q_addr_flat,
  output logic                    addr_hit
);

  logic [NUM_Q-1:0] hit_vec;

  generate
    for (genvar q = 0; q < int'(NUM_Q); q++) begin : g_cmp
      assign hit_vec[q] = (wr_addr == q_addr_flat[q*ADDR_W +: ADDR_W]);
    end
  endgenerate

  assign addr_hit = |hit_vec;

endmodule

// File: rtl/ntf_idx_check.sv
module ntf_idx_check #(
  parameter int unsigned NUM_Q = 4
) (
  input  logic [15:0]      idx,
  input  logic [NUM_Q-1:0] q_enable,
  output logic             idx_ok
);

  logic [NUM_Q-1:0] sel_ok;

  generate
    for (genvar q = 0; q < int'(NUM_Q); q++) begin : g_sel
      assign sel_ok[q] = (idx == 16'(q)) && q_enable[q];
    end
  endgenerate

  assign idx_ok = |sel_ok;

endmodule

// File: rtl/ntf_decoder.sv
module ntf_decoder
  import ntf_pkg::*;
#(
  parameter int unsigned NUM_Q    = 4,
  parameter int unsigned OFF_W    = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned MULT     = 4,
  parameter int unsigned BASE_OFF = 256,
  parameter int unsigned DROP_W   = 8,
  localparam int unsigned QSEL_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [1:0]              wr_size,
  input  logic [15:0]             wr_data,
  input  logic [NUM_Q*OFF_W-1:0]  q_notify_off,
  input  logic [NUM_Q-1:0]        q_enable,
  input  logic [QSEL_W-1:0]       qry_sel,
  output logic [ADDR_W-1:0]       qry_addr,
  output logic                    ntf_valid,
  output logic [15:0]             ntf_qidx,
  output logic                    drop_valid,
  output logic [DROP_W-1:0]       drop_cnt
);

  localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

  initial begin
    AST_MULT_LEGAL: assert (mult_is_legal(MULT) && (BASE_OFF % 2 == 0))
      else $error("ntf_decoder: illegal MULT=%0d or odd BASE_OFF=%0d", MULT, BASE_OFF); // R11
  end

  logic [NUM_Q*ADDR_W-1:0] q_addr_flat;
  logic                    addr_hit;
  logic                    idx_ok;

  ntf_addr_calc #(
    .NUM_Q(NUM_Q), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .MULT(MULT), .BASE_OFF(BASE_OFF)
  ) u_calc (
    .q_off_flat  (q_notify_off),
    .q_addr_flat (q_addr_flat)
  );

  ntf_addr_match #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) u_match (
    .wr_addr     (wr_addr),
    .q_addr_flat (q_addr_flat),
    .addr_hit    (addr_hit)
  );

  ntf_idx_check #(.NUM_Q(NUM_Q)) u_idx (
    .idx      (wr_data),
    .q_enable (q_enable),
    .idx_ok   (idx_ok)
  );

  // Address query
  always_comb begin
    qry_addr = '0;
    for (int q = 0; q < int'(NUM_Q); q++) begin
      if (qry_sel == QSEL_W'(q)) qry_addr = q_addr_flat[q*ADDR_W +: ADDR_W];
    end
  end

  // Next state
  logic              accept;
  logic              drop;
  logic              ntf_valid_d;
  logic [15:0]       ntf_qidx_d;
  logic              ntf_qidx_en;
  logic              drop_valid_d;
  logic [DROP_W-1:0] drop_cnt_d;
  logic              drop_cnt_en;

  always_comb begin
    accept       = wr_valid && (wr_size == WSZ_16) && addr_hit && idx_ok;
    drop         = wr_valid && !accept;
    ntf_valid_d  = accept;
    ntf_qidx_en  = accept;
    ntf_qidx_d   = wr_data;
    drop_valid_d = drop;
    drop_cnt_en  = drop && (drop_cnt != DROP_MAX);
    drop_cnt_d   = drop_cnt + DROP_W'(1);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ntf_valid  <= 1'b0;
      ntf_qidx   <= '0;
      drop_valid <= 1'b0;
      drop_cnt   <= '0;
    end else begin
      ntf_valid  <= ntf_valid_d;
      drop_valid <= drop_valid_d;
      if (ntf_qidx_en) ntf_qidx <= ntf_qidx_d;
      if (drop_cnt_en) drop_cnt <= drop_cnt_d;
    end
  end

  // Assertions
  AST_NTF_FROM_HALFWORD: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> ($past(wr_valid) && ($past(wr_size) == WSZ_16))); // R6

  AST_NTF_IDX_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> (ntf_qidx == $past(wr_data))); // R3

  AST_NTF_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> (32'(ntf_qidx) < NUM_Q)); // R4

  AST_NTF_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> ((($past(q_enable) >> ntf_qidx) & NUM_Q'(1)) != '0)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_valid) |-> (!ntf_valid && !drop_valid)); // R3

  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ntf_valid && drop_valid)); // R9

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_valid && ($past(drop_cnt) != DROP_MAX)) |-> (drop_cnt == $past(drop_cnt) + DROP_W'(1))); // R9

  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_valid |-> $stable(drop_cnt)); // R9

endmodule

// File: tb/ntf_decoder_tb.sv
module ntf_decoder_tb;

  localparam int NQ   = 4;
  localparam int OW   = 8;
  localparam int AW   = 12;
  localparam int BASE = 256;
  localparam int MA   = 4;
  localparam int DW   = 4;
  localparam int DMAX = (1 << DW) - 1;

  logic            clk;
  logic            rst_n;
  logic            wr_valid;
  logic [AW-1:0]   wr_addr;
  logic [1:0]      wr_size;
  logic [15:0]     wr_data;
  logic [NQ*OW-1:0] q_off;
  logic [NQ-1:0]   q_en;
  logic [1:0]      qry_sel;

  logic [AW-1:0]   qa_a, qa_z;
  logic            nv_a, nv_z, dv_a, dv_z;
  logic [15:0]     ni_a, ni_z;
  logic [DW-1:0]   dc_a, dc_z;

  ntf_decoder #(.NUM_Q(NQ), .OFF_W(OW), .ADDR_W(AW), .MULT(MA), .BASE_OFF(BASE), .DROP_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .q_notify_off(q_off), .q_enable(q_en), .qry_sel(qry_sel),
    .qry_addr(qa_a), .ntf_valid(nv_a), .ntf_qidx(ni_a), .drop_valid(dv_a), .drop_cnt(dc_a)
  );

  ntf_decoder #(.NUM_Q(NQ), .OFF_W(OW), .ADDR_W(AW), .MULT(0), .BASE_OFF(BASE), .DROP_W(DW)) u_dut_z (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .q_notify_off(q_off), .q_enable(q_en), .qry_sel(qry_sel),
    .qry_addr(qa_z), .ntf_valid(nv_z), .ntf_qidx(ni_z), .drop_valid(dv_z), .drop_cnt(dc_z)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int offs[NQ] = '{0, 1, 3, 1};   // queues 1 and 3 share an offset
  int exp_da = 0;
  int exp_dz = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit hit_a(input int addr);
    for (int q = 0; q < NQ; q++) if (BASE + offs[q] * MA == addr) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string why(input bit acc, input bit hit, input int sz, input int d, input logic [NQ-1:0] en, input string acc_tag);
    if (acc) return acc_tag;
    if (sz != 1) return "R6";
    if (!hit) return "R7";
    if (d >= NQ) return "R4";
    return "R5";
  endfunction

  task automatic one_write(input int addr, input int sz, input int d);
    bit hit, ok_idx, acc_a, acc_z;
    string ta, tz;
    hit    = hit_a(addr);
    ok_idx = (d < NQ) && q_en[d % NQ];
    acc_a  = (sz == 1) && hit && ok_idx;
    acc_z  = (sz == 1) && (addr == BASE) && ok_idx;
    wr_valid = 1'b1; wr_addr = AW'(addr); wr_size = 2'(sz); wr_data = 16'(d);
    @(negedge clk);
    wr_valid = 1'b0;
    ta = why(acc_a, hit, sz, d, q_en, (addr == BASE + MA) ? "R8" : "R3");
    tz = why(acc_z, addr == BASE, sz, d, q_en, "R2");
    check(nv_a == acc_a, ta, nv_a, acc_a);
    if (acc_a) check(ni_a == 16'(d), ta, ni_a, d);
    check(nv_z == acc_z, tz, nv_z, acc_z);
    if (acc_z) check(ni_z == 16'(d), "R2", ni_z, d);
    if (!acc_a && exp_da < DMAX) exp_da++;
    if (!acc_z && exp_dz < DMAX) exp_dz++;
    check(dv_a == !acc_a, "R9", dv_a, !acc_a);
    check(dv_z == !acc_z, "R9", dv_z, !acc_z);
    check(int'(dc_a) == exp_da, "R9", dc_a, exp_da);
    check(int'(dc_z) == exp_dz, "R9", dc_z, exp_dz);
    @(negedge clk);
    // R3: the pulse lasts one cycle; R9: counter holds while idle
    check(!nv_a && !nv_z, "R3", {nv_a, nv_z}, 0);
    check(!dv_a && !dv_z && int'(dc_a) == exp_da, "R9", dc_a, exp_da);
  endtask

  initial begin
    wr_valid = 1'b0; wr_addr = '0; wr_size = '0; wr_data = '0;
    q_en = '0; qry_sel = '0;
    for (int q = 0; q < NQ; q++) q_off[q*OW +: OW] = OW'(offs[q]);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!nv_a && ni_a == 0 && !dv_a && dc_a == 0, "R10", {nv_a, dv_a, dc_a}, 0);
    check(!nv_z && ni_z == 0 && !dv_z && dc_z == 0, "R10", {nv_z, dv_z, dc_z}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: layout query
    for (int q = 0; q < NQ; q++) begin
      qry_sel = 2'(q);
      #1;
      check(int'(qa_a) == BASE + offs[q] * MA, "R1", qa_a, BASE + offs[q] * MA);
      check(int'(qa_z) == BASE, "R2", qa_z, BASE);
    end
    // R11: the legal scaling multiplier places queue 1 one multiplier step above the base
    qry_sel = 2'd1;
    #1;
    check(int'(qa_a) - int'(qa_z) == MA, "R11", int'(qa_a) - int'(qa_z), MA);
    @(negedge clk);

    // Sweeps under two enable patterns
    for (int p = 0; p < 2; p++) begin
      q_en = (p == 0) ? 4'b1111 : 4'b1011;
      @(negedge clk);
      for (int a = BASE - 3; a <= BASE + 14; a++)
        for (int s = 0; s < 4; s++)
          for (int d = 0; d < 6; d++)
            one_write(a, s, d);
    end
    // R4: large index on a valid address
    q_en = 4'b1111;
    one_write(BASE, 1, 16'h8001);
    // R8: both sharers of the shared address
    one_write(BASE + MA, 1, 1);
    one_write(BASE + MA, 1, 3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule